// File: doc/BRIEF.md
# Narrow-Bus Staging Bridge for Wide Registers

The bridge connects a CPU bus that moves 8 or 16 bits per cycle to a bank of 32-bit internal registers. Every bus write drops one byte or one halfword into a 32-bit staging word. When the access also carries the commit address bit (bit 8), the bridge copies the staging word into the register selected by address bits 7..2 within that clock edge. The copy includes the lane being written in that same cycle. Lanes that were not written keep what they held, so software can update one byte of a wide register without rebuilding the other three.

A read with bit 8 set loads the selected register into the staging word, and the addressed lane appears on the read bus in the next cycle. A read with bit 8 clear returns a lane of the staging word directly. Two directly addressed words, the pointer at offset 0x0F8 and the window at offset 0x0FC, reach a small indirect register space. An optional mode commits automatically whenever the top lane is written, so a full word written in ascending lane order lands by itself.

Top module: `hbb_bridge`

## Requirements
- R1: After reset the staging word, every bank register, the pointer and every indirect register are zero, so every read returns 0.
- R2: When `wide_mode`=0, a write loads `wdata[7:0]` into staging byte `addr[1:0]`, where byte n is bits 8n+7..8n. A read returns that byte on `rdata[7:0]`, with `rdata[15:8]`=0.
- R3: When `wide_mode`=1, a write loads `wdata` into the staging half chosen by `addr[1]` (1 selects bits 31..16, 0 selects bits 15..0), and a read returns that half on `rdata`.
- R4: Each write changes only its own lane. Lanes can be rewritten in any order, and the most recent value is the one kept.
- R5: A write with `addr[8]`=1 commits the staging word, merged with the lane being written, into the target register at the same clock edge.
- R6: A read strobe with `addr[8]`=1 loads the target register into the staging word, and `rdata` shows the addressed lane from the following cycle on.
- R7: A copy read followed by a single byte write with `addr[8]`=1 to the same location changes only that byte of the target register.
- R8: A read with `addr[8]`=0 does not touch any register and returns a lane of the current staging word. Offset 0x0F4 is the canonical address for this.
- R9: Word index 0x3E (offset 0x0F8) is the indirect pointer. Word index 0x3F (offset 0x0FC) is the window onto indirect register number pointer. A pointer at or beyond `NIND` reads zero and ignores commits.
- R10: Word indices from `NREG` through 0x3C are unimplemented. They read zero and ignore commits.
- R11: When `auto_commit`=1, a write to byte 3 (8-bit mode) or to the upper half (16-bit mode) commits even when `addr[8]`=0.
- R12: When `auto_commit`=0, writes with `addr[8]`=0 never change any register other than the staging word.
- R13: Word index 0x3D (offset 0x0F4) with `addr[8]`=1 targets the staging word itself. A commit there changes nothing beyond the lane write, and a copy read leaves the staging word as it is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide_mode | input | 1 | 1 selects a 16-bit bus, 0 selects an 8-bit bus |
| auto_commit | input | 1 | 1 commits automatically when the top lane is written |
| wr_en | input | 1 | Single-cycle write strobe; takes priority over `rd_en` |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 9 | Bit 8 commits or copies; bits 7..2 are the word index; bits 1..0 select the lane |
| wdata | input | 16 | Write data; only bits 7..0 are used in 8-bit mode |
| rdata | output | 16 | Selected lane of the staging word |

## Verification
In one clock edge a write both merges its lane into the staging word and commits that merged word to a target. A stale commit that misses the fresh lane, or a merge that clobbers a neighbouring lane, shows up only when the two happen together. The bench provokes this with partial byte and halfword writes that carry bit 8, interleaved with unrelated staging writes, copy reads and switches between bus widths. It judges each result by reading the target back through a later copy read and comparing it with a reference model that keeps the staging word and all registers separately.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
  localparam int WORD_W = 32;
  localparam int BUS_W  = 16;
  localparam int IDX_W  = 6;

  localparam logic [IDX_W-1:0] IDX_STAGE = 6'h3D;
  localparam logic [IDX_W-1:0] IDX_PTR   = 6'h3E;
  localparam logic [IDX_W-1:0] IDX_WIN   = 6'h3F;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_BANK,
    TGT_STAGE,
    TGT_PTR,
    TGT_WIN
  } tgt_e;

  // Merge one bus lane into a 32-bit word.
  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_w,
                                                   input logic [BUS_W-1:0]  d,
                                                   input logic [1:0]        lsb,
                                                   input logic              wide);
    logic [WORD_W-1:0] r;
    r = old_w;
    if (wide) begin
      if (lsb[1]) r[31:16] = d;
      else        r[15:0]  = d;
    end else begin
      case (lsb)
        2'd0:    r[7:0]   = d[7:0];
        2'd1:    r[15:8]  = d[7:0];
        2'd2:    r[23:16] = d[7:0];
        default: r[31:24] = d[7:0];
      endcase
    end
    return r;
  endfunction

  // Byte lanes touched by one write.
  function automatic logic [3:0] lane_mask(input logic [1:0] lsb, input logic wide);
    if (wide) return lsb[1] ? 4'b1100 : 4'b0011;
    return 4'b0001 << lsb;
  endfunction

  // Lane returned on the read bus.
  function automatic logic [BUS_W-1:0] lane_pick(input logic [WORD_W-1:0] w,
                                                 input logic [1:0]        lsb,
                                                 input logic              wide);
    logic [7:0] b;
    if (wide) return lsb[1] ? w[31:16] : w[15:0];
    case (lsb)
      2'd0:    b = w[7:0];
      2'd1:    b = w[15:8];
      2'd2:    b = w[23:16];
      default: b = w[31:24];
    endcase
    return {8'h00, b};
  endfunction

  // True when the write hits the most significant lane.
  function automatic logic top_lane(input logic [1:0] lsb, input logic wide);
    return wide ? lsb[1] : (&lsb);
  endfunction

  // Word index to target class.
  function automatic tgt_e decode_target(input logic [IDX_W-1:0] idx, input int nreg);
    if (int'({26'd0, idx}) < nreg) return TGT_BANK;
    case (idx)
      IDX_STAGE: return TGT_STAGE;
      IDX_PTR:   return TGT_PTR;
      IDX_WIN:   return TGT_WIN;
      default:   return TGT_NONE;
    endcase
  endfunction
endpackage

// File: rtl/hbb_ctrl.sv
module hbb_ctrl
  import hbb_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [8:0] addr,
  input  logic       wide_mode,
  input  logic       auto_commit,
  output logic       load_en,
  output logic       commit_en,
  output logic       copy_en,
  output tgt_e       tgt
);
  logic auto_hit;

  assign tgt       = decode_target(addr[7:2], NREG);
  assign load_en   = wr_en;
  assign auto_hit  = auto_commit & top_lane(addr[1:0], wide_mode);
  assign commit_en = wr_en & (addr[8] | auto_hit);
  assign copy_en   = rd_en & ~wr_en & addr[8];

  // R11: a top-lane write in auto mode must commit
  a_r11_auto_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_commit && wr_en && ((wide_mode && addr[1]) || (!wide_mode && addr[1:0] == 2'd3)))
    |-> commit_en);

  // R12: without bit 8 and without auto mode nothing commits
  a_r12_no_stray_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_commit && !addr[8]) |-> !commit_en);

  // R8: reads never commit, copies need bit 8
  a_r8_read_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |-> (!commit_en && (copy_en == (rd_en && addr[8]))));
endmodule

// File: rtl/hbb_stage.sv
module hbb_stage
  import hbb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              wide,
  input  logic [1:0]        lsb,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              copy_en,
  input  logic [WORD_W-1:0] copy_word,
  output logic [WORD_W-1:0] stage_q,
  output logic [WORD_W-1:0] stage_nx
);
  logic [3:0] hit_mask;

  assign stage_nx = lane_merge(stage_q, wdata, lsb, wide);
  assign hit_mask = lane_mask(lsb, wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stage_q <= '0;
    else if (load_en) stage_q <= stage_nx;
    else if (copy_en) stage_q <= copy_word;
  end

  generate
    for (genvar k = 0; k < 4; k++) begin : g_lane
      // R4: lanes outside the write keep their value
      a_r4_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !hit_mask[k]) |=> $stable(stage_q[8*k +: 8]));
    end
  endgenerate

  // R4: a write touches one byte or one half
  a_r4_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> ($countones(hit_mask) == (wide ? 2 : 1)));
endmodule

// File: rtl/hbb_regbank.sv
module hbb_regbank
  import hbb_pkg::*;
#(
  parameter int NREG = 16,
  parameter int NIND = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tgt_e              tgt,
  input  logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] bidx,
  input  logic              commit_en,
  input  logic [WORD_W-1:0] commit_word,
  output logic [WORD_W-1:0] rd_word
);
  localparam int BW = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int IW = (NIND > 1) ? $clog2(NIND) : 1;

  logic [WORD_W-1:0] bank_q [NREG];
  logic [WORD_W-1:0] ind_q  [NIND];
  logic [WORD_W-1:0] ptr_q;
  logic              win_ok;
  logic [IW-1:0]     iidx;
  logic              bank_we, ptr_we, win_we;

  assign win_ok  = (ptr_q < WORD_W'(NIND));
  assign iidx    = ptr_q[IW-1:0];
  assign bank_we = commit_en && (tgt == TGT_BANK);
  assign ptr_we  = commit_en && (tgt == TGT_PTR);
  assign win_we  = commit_en && (tgt == TGT_WIN) && win_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank_q[i] <= '0;
    end else if (bank_we) begin
      for (int i = 0; i < NREG; i++)
        if (bidx == BW'(i)) bank_q[i] <= commit_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < NIND; j++) ind_q[j] <= '0;
    end else if (win_we) begin
      for (int j = 0; j < NIND; j++)
        if (iidx == IW'(j)) ind_q[j] <= commit_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_we) ptr_q <= commit_word;
  end

  always_comb begin
    case (tgt)
      TGT_BANK: rd_word = bank_q[bidx];
      TGT_PTR:  rd_word = ptr_q;
      TGT_WIN:  rd_word = win_ok ? ind_q[iidx] : '0;
      default:  rd_word = '0;
    endcase
  end

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      // R5: a commit lands in the selected register at the same edge
      a_r5_single_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && tgt == TGT_BANK && bidx == BW'(i)) |=> (bank_q[i] == $past(commit_word)));
    end
  endgenerate

  // R9: pointer commit
  a_r9_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && tgt == TGT_PTR) |=> (ptr_q == $past(commit_word)));

  // R9: an out-of-range window reads zero
  a_r9_window_range: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_WIN && !win_ok) |-> (rd_word == '0));

  // R10: unimplemented indices read zero and leave the pointer alone
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_NONE) |-> (rd_word == '0));
  a_r10_unmapped_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_en && tgt == TGT_NONE) |=> $stable(ptr_q));
endmodule

// File: rtl/hbb_bridge.sv
module hbb_bridge
  import hbb_pkg::*;
#(
  parameter int NREG = 16,
  parameter int NIND = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide_mode,
  input  logic        auto_commit,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [8:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata
);
  localparam int BW = (NREG > 1) ? $clog2(NREG) : 1;

  logic              load_en, commit_en, copy_en;
  tgt_e              tgt;
  logic [WORD_W-1:0] stage_q, stage_nx, rd_word, copy_word;

  hbb_ctrl #(.NREG(NREG)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wide_mode   (wide_mode),
    .auto_commit (auto_commit),
    .load_en     (load_en),
    .commit_en   (commit_en),
    .copy_en     (copy_en),
    .tgt         (tgt)
  );

  hbb_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .wide      (wide_mode),
    .lsb       (addr[1:0]),
    .wdata     (wdata),
    .copy_en   (copy_en),
    .copy_word (copy_word),
    .stage_q   (stage_q),
    .stage_nx  (stage_nx)
  );

  hbb_regbank #(.NREG(NREG), .NIND(NIND)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt         (tgt),
    .bidx        (addr[2 +: BW]),
    .commit_en   (commit_en),
    .commit_word (stage_nx),
    .rd_word     (rd_word)
  );

  assign copy_word = (tgt == TGT_STAGE) ? stage_q : rd_word;
  assign rdata     = lane_pick(stage_q, addr[1:0], wide_mode);

  // R6: a copy read loads the target word into staging
  a_r6_copy_loads: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |=> (stage_q == $past(rd_word) || $past(tgt) == TGT_STAGE));

  // R13: copying the staging word onto itself changes nothing
  a_r13_self_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_en && tgt == TGT_STAGE) |=> $stable(stage_q));

  // R8: a cycle with no strobe leaves the staging word alone
  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> $stable(stage_q));
endmodule

// File: tb/hbb_bridge_tb.sv
module hbb_bridge_tb;
  localparam int NREG = 16;
  localparam int NIND = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide_mode = 1'b0;
  logic        auto_commit = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [8:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_stage;
  logic [31:0] m_bank [NREG];
  logic [31:0] m_ind  [NIND];
  logic [31:0] m_ptr;

  hbb_bridge #(.NREG(NREG), .NIND(NIND)) u_dut (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .auto_commit(auto_commit),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #10 clk = ~clk;

  function automatic logic [8:0] ad(input bit b8, input int idx, input int ln);
    return {b8, idx[5:0], ln[1:0]};
  endfunction

  // Bench view of the lane a write touches, written as shift and mask.
  function automatic logic [31:0] m_merge(input logic [31:0] w, input logic [15:0] d,
                                          input logic [1:0] ln, input bit wide);
    logic [31:0] msk, val;
    if (wide) begin
      msk = 32'h0000_FFFF << (ln[1] * 16);
      val = {16'h0, d} << (ln[1] * 16);
    end else begin
      msk = 32'h0000_00FF << (ln * 8);
      val = {24'h0, d[7:0]} << (ln * 8);
    end
    return (w & ~msk) | (val & msk);
  endfunction

  function automatic logic [15:0] m_pick(input logic [31:0] w, input logic [1:0] ln, input bit wide);
    logic [31:0] s;
    if (wide) begin
      s = w >> (ln[1] * 16);
      return s[15:0];
    end
    s = w >> (ln * 8);
    return {8'h00, s[7:0]};
  endfunction

  function automatic logic [31:0] m_target(input logic [5:0] idx);
    if (idx < NREG) return m_bank[idx];
    if (idx == 6'h3E) return m_ptr;
    if (idx == 6'h3F) return (m_ptr < NIND) ? m_ind[m_ptr[2:0]] : 32'h0;
    return 32'h0;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: rdata=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [15:0] d);
    bit com;
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    m_stage = m_merge(m_stage, d, a[1:0], wide_mode);
    com = a[8] || (auto_commit && (wide_mode ? a[1] : (a[1:0] == 2'd3)));
    if (com) begin
      if (a[7:2] < NREG) m_bank[a[7:2]] = m_stage;
      else if (a[7:2] == 6'h3E) m_ptr = m_stage;
      else if (a[7:2] == 6'h3F && m_ptr < NIND) m_ind[m_ptr[2:0]] = m_stage;
    end
  endtask

  task automatic do_read(input logic [8:0] a, input string req);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    if (a[8] && a[7:2] != 6'h3D) m_stage = m_target(a[7:2]);
    check(req, rdata, m_pick(m_stage, a[1:0], wide_mode));
  endtask

  task automatic write_word8(input bit b8, input int idx, input logic [31:0] w);
    for (int l = 0; l < 4; l++) do_write(ad(b8 && l == 3, idx, l), {8'h00, w[8*l +: 8]});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: rdata=%h expected=done", rdata);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1394_5A5A));
    m_stage = '0; m_ptr = '0;
    for (int i = 0; i < NREG; i++) m_bank[i] = '0;
    for (int j = 0; j < NIND; j++) m_ind[j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    #1 check("R1 staging", rdata, 16'h0);
    do_read(ad(1, 2, 1), "R1 bank");
    do_read(ad(1, 6'h3F, 0), "R1 window");

    // R2 / R4: byte lanes in 8-bit mode, rewrite and order
    do_write(ad(0, 6'h3D, 2), 16'h00C3);
    do_write(ad(0, 6'h3D, 0), 16'h0011);
    do_write(ad(0, 6'h3D, 3), 16'h00D4);
    do_write(ad(0, 6'h3D, 1), 16'h0022);
    do_write(ad(0, 6'h3D, 1), 16'h0077);
    for (int l = 0; l < 4; l++) do_read(ad(0, 6'h3D, l), "R2 R4 R8 byte lane");

    // R3: halves in 16-bit mode
    wide_mode = 1'b1;
    do_write(ad(0, 6'h3D, 2), 16'hBEEF);
    do_read(ad(0, 6'h3D, 2), "R3 upper half");
    do_read(ad(0, 6'h3D, 0), "R3 lower half kept");
    wide_mode = 1'b0;
    do_read(ad(0, 6'h3D, 3), "R3 half seen as byte");

    // R5: commit on the last byte, merged in the same edge
    write_word8(1, 5, 32'hA1B2C3D4);
    write_word8(0, 6'h3D, 32'h0);
    do_read(ad(1, 5, 3), "R5 committed byte3");
    do_read(ad(0, 6'h3D, 0), "R5 R6 committed byte0");

    // R7: read-modify-write of one byte
    do_read(ad(1, 5, 2), "R7 copy");
    do_write(ad(1, 5, 2), 16'h005E);
    write_word8(0, 6'h3D, 32'hFFFF_FFFF);
    do_read(ad(1, 5, 0), "R7 byte0 unchanged");
    for (int l = 1; l < 4; l++) do_read(ad(0, 6'h3D, l), "R7 lanes");

    // R9: pointer and window in 16-bit mode
    wide_mode = 1'b1;
    do_write(ad(0, 6'h3E, 0), 16'h0003);
    do_write(ad(1, 6'h3E, 2), 16'h0000);
    do_write(ad(0, 6'h3F, 0), 16'h1234);
    do_write(ad(1, 6'h3F, 2), 16'h5678);
    do_write(ad(0, 6'h3E, 0), 16'h0004);
    do_write(ad(1, 6'h3E, 2), 16'h0000);
    do_write(ad(1, 6'h3F, 0), 16'h9999);
    do_write(ad(0, 6'h3E, 0), 16'h0003);
    do_write(ad(1, 6'h3E, 2), 16'h0000);
    do_read(ad(1, 6'h3F, 2), "R9 window upper");
    do_read(ad(1, 6'h3F, 0), "R9 window lower");
    do_write(ad(0, 6'h3E, 0), 16'h0040);
    do_write(ad(1, 6'h3E, 2), 16'h0000);
    do_write(ad(1, 6'h3F, 0), 16'hAAAA);
    do_read(ad(1, 6'h3F, 0), "R9 out of range");

    // R10: unimplemented index
    do_write(ad(1, 6'h30, 0), 16'hC0DE);
    do_read(ad(1, 6'h30, 0), "R10 unmapped reads zero");
    do_read(ad(1, 6'h3E, 0), "R10 pointer untouched");

    // R13: self target
    do_write(ad(0, 6'h3D, 0), 16'h4242);
    do_read(ad(1, 6'h3D, 0), "R13 self copy");

    // R11 / R12: auto mode on and off
    wide_mode = 1'b0; auto_commit = 1'b1;
    write_word8(0, 7, 32'h0BAD_F00D);
    write_word8(0, 6'h3D, 32'h0);
    do_read(ad(1, 7, 1), "R11 auto commit");
    auto_commit = 1'b0;
    write_word8(0, 8, 32'h1357_9BDF);
    do_read(ad(1, 8, 3), "R12 no commit");

    // Random mix: merge and commit in the same edge, copies, width switches
    for (int n = 0; n < 600; n++) begin
      int pick, idx, ln;
      pick = $urandom_range(0, 9);
      idx  = (pick < 7) ? $urandom_range(0, NREG - 1) :
             (pick == 7) ? 6'h3F : (pick == 8) ? 6'h3D : 6'h31;
      ln   = $urandom_range(0, 3);
      wide_mode   = ($urandom_range(0, 3) == 0);
      auto_commit = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 2) != 0)
        do_write(ad($urandom_range(0, 1) == 1, idx, ln), 16'($urandom));
      else
        do_read(ad($urandom_range(0, 2) != 0, idx, ln), "R5 R6 R7 random");
    end
    wide_mode = 1'b0;
    for (int i = 0; i < NREG; i++) do_read(ad(1, i, 0), "R5 final bank sweep");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule